// File: doc/BRIEF.md
# Split-Transaction Descriptor Status Updater

This block keeps the status portion of a single transfer descriptor that drives a bulk transfer carried as a split transaction: a start split followed by one or more complete splits. Software arms the descriptor through a load port. The load gives the initial error budget, the NAK reload value and the starting data toggle. After that, the host engine reports each bus transaction result as a one-cycle strobe carrying an encoded outcome and the number of bytes moved.

On each accepted outcome the block updates its flags, its phase bit, its data toggle, its byte field and its two retry counters. The error counter counts down on missing or corrupt responses and is refilled on flow-control answers. The NAK counter counts down on NAKs, but only when its reload value is nonzero. When any condition ends the descriptor, valid and active drop together and a one-cycle retire pulse is issued. Every output is registered and shows the effect of a strobe right after the clock edge that samples it.

Top module: `split_td_status`

## Requirements
- R1: A load sets valid and active to 1 and clears halt, babble and transaction-error. It sets the phase to start split (phase bit 0), clears the byte field, sets the error counter and its reload value to the loaded error value, sets the NAK counter and its reload value to the loaded RL value, and sets the data toggle to the loaded toggle.
- R2: Outcome codes are ACK=0, NAK=1, NYET=2, no response=3, bad response=4, babble=5, stall=6. Code 7 is reserved. A strobe that arrives while valid is 0, or that carries code 7, changes no output.
- R3: An ACK in the start-split phase moves the phase bit to 1 (complete split). Valid stays 1 and no retire pulse is issued.
- R4: An ACK in the complete-split phase inverts the data toggle, writes the strobe's byte count into the byte field, and clears valid and active.
- R5: No response or bad response decrements the error counter, which holds at 0. When the result is 0, transaction-error is set, valid and active are cleared, and the descriptor retires.
- R6: NAK or NYET reloads the error counter with its loaded value.
- R7: With a nonzero RL, a NAK decrements the NAK counter, and reaching 0 clears valid and active and retires the descriptor. With RL equal to 0, NAKs leave the NAK counter and valid unchanged.
- R8: NAK and NYET leave the phase bit unchanged.
- R9: Babble sets the babble flag and clears valid and active.
- R10: Stall sets the halt flag and clears valid and active.
- R11: The retire output is high for exactly the one cycle following the edge on which an outcome cleared valid, and is low otherwise.
- R12: When a load and an outcome strobe arrive in the same cycle, the load takes effect and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Software arm strobe |
| load_err_i | input | ERR_W | Initial and reload value of the error counter |
| load_rl_i | input | NAK_W | NAK reload value (0 means NAKs never retire) |
| load_tog_i | input | 1 | Initial data toggle |
| res_vld_i | input | 1 | One-cycle outcome strobe |
| res_code_i | input | 3 | Encoded transaction outcome |
| res_bytes_i | input | BYTE_W | Bytes sent or received in the transaction |
| valid_o | output | 1 | Descriptor valid |
| active_o | output | 1 | Descriptor active |
| halt_o | output | 1 | Halted by stall |
| babble_o | output | 1 | Babble seen |
| xact_err_o | output | 1 | Error budget exhausted |
| phase_o | output | 1 | 0 start split, 1 complete split |
| toggle_o | output | 1 | Data toggle |
| err_cnt_o | output | ERR_W | Error counter |
| nak_cnt_o | output | NAK_W | NAK counter |
| bytes_o | output | BYTE_W | Bytes moved by the last completing transaction |
| retire_o | output | 1 | One-cycle retire pulse |

## Verification
The two functions that can fall in the same cycle are the software arm and the outcome update. The bench raises the load strobe and a stall strobe together on a descriptor that is already armed. It then judges the result at the outputs: halt stays clear, valid stays high, the counters hold the freshly loaded values, and no retire pulse appears. A second kind of overlap lies inside the outcome path, where a decrement and a retire decision are made in the same cycle. Driving the error and NAK counters down to their last step checks that the flag, the valid drop and the retire pulse all appear after that one edge.

// File: rtl/split_td_pkg.sv
package split_td_pkg;

  typedef enum logic [2:0] {
    OC_ACK     = 3'd0,
    OC_NAK     = 3'd1,
    OC_NYET    = 3'd2,
    OC_NORESP  = 3'd3,
    OC_BADRESP = 3'd4,
    OC_BABBLE  = 3'd5,
    OC_STALL   = 3'd6,
    OC_RSVD    = 3'd7
  } outcome_e;

  typedef struct packed {
    logic ack;
    logic nak;
    logic nyet;
    logic fault;   // no response or bad response
    logic babble;
    logic stall;
  } evt_t;

endpackage

// File: rtl/split_outcome_dec.sv
module split_outcome_dec
  import split_td_pkg::*;
(
  input  logic       en_i,
  input  logic [2:0] code_i,
  output evt_t       evt_o
);

  always_comb begin
    evt_o = '0;
    if (en_i) begin
      unique case (outcome_e'(code_i))
        OC_ACK:     evt_o.ack    = 1'b1;
        OC_NAK:     evt_o.nak    = 1'b1;
        OC_NYET:    evt_o.nyet   = 1'b1;
        OC_NORESP,
        OC_BADRESP: evt_o.fault  = 1'b1;
        OC_BABBLE:  evt_o.babble = 1'b1;
        OC_STALL:   evt_o.stall  = 1'b1;
        default:    evt_o        = '0;
      endcase
    end
  end

endmodule

// File: rtl/split_retry_ctr.sv
// Down-counter with a stored reload value. When GATE_ON_ZERO is set, a
// reload value of zero disables counting and expiry altogether.
module split_retry_ctr #(
  parameter int W            = 2,
  parameter bit GATE_ON_ZERO = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         reload_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] init_q, init_d;
  logic         armed;
  logic         cnt_en;

  generate
    if (GATE_ON_ZERO) begin : g_gated
      assign armed = (init_q != '0);
    end else begin : g_free
      assign armed = 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_d  = cnt_q;
    init_d = init_q;
    if (load_i) begin
      cnt_d  = load_val_i;
      init_d = load_val_i;
    end else if (reload_i) begin
      cnt_d = init_q;
    end else if (dec_i && armed) begin
      cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
    end
  end

  assign cnt_en   = load_i | reload_i | (dec_i & armed);
  assign expire_o = dec_i & armed & (cnt_q <= ONE);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      init_q <= '0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      init_q <= init_d;
    end
  end

endmodule

// File: rtl/split_td_status.sv
module split_td_status
  import split_td_pkg::*;
#(
  parameter int ERR_W  = 2,
  parameter int NAK_W  = 4,
  parameter int BYTE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ERR_W-1:0]  load_err_i,
  input  logic [NAK_W-1:0]  load_rl_i,
  input  logic              load_tog_i,
  input  logic              res_vld_i,
  input  logic [2:0]        res_code_i,
  input  logic [BYTE_W-1:0] res_bytes_i,
  output logic              valid_o,
  output logic              active_o,
  output logic              halt_o,
  output logic              babble_o,
  output logic              xact_err_o,
  output logic              phase_o,
  output logic              toggle_o,
  output logic [ERR_W-1:0]  err_cnt_o,
  output logic [NAK_W-1:0]  nak_cnt_o,
  output logic [BYTE_W-1:0] bytes_o,
  output logic              retire_o
);

  evt_t evt;
  logic accept;
  logic err_expire, nak_expire;

  logic valid_q, valid_d, active_q, active_d;
  logic halt_q, halt_d, babble_q, babble_d, xerr_q, xerr_d;
  logic phase_q, phase_d, tog_q, tog_d, retire_q, retire_d;
  logic [BYTE_W-1:0] bytes_q, bytes_d;

  assign accept = res_vld_i & valid_q & ~load_i;

  split_outcome_dec u_dec (
    .en_i   (accept),
    .code_i (res_code_i),
    .evt_o  (evt)
  );

  split_retry_ctr #(.W(ERR_W), .GATE_ON_ZERO(1'b0)) u_err_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .load_val_i (load_err_i),
    .reload_i   (evt.nak | evt.nyet),
    .dec_i      (evt.fault),
    .cnt_o      (err_cnt_o),
    .expire_o   (err_expire)
  );

  split_retry_ctr #(.W(NAK_W), .GATE_ON_ZERO(1'b1)) u_nak_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .load_val_i (load_rl_i),
    .reload_i   (1'b0),
    .dec_i      (evt.nak),
    .cnt_o      (nak_cnt_o),
    .expire_o   (nak_expire)
  );

  always_comb begin
    valid_d  = valid_q;
    active_d = active_q;
    halt_d   = halt_q;
    babble_d = babble_q;
    xerr_d   = xerr_q;
    phase_d  = phase_q;
    tog_d    = tog_q;
    bytes_d  = bytes_q;
    retire_d = 1'b0;
    if (load_i) begin
      valid_d  = 1'b1;
      active_d = 1'b1;
      halt_d   = 1'b0;
      babble_d = 1'b0;
      xerr_d   = 1'b0;
      phase_d  = 1'b0;
      tog_d    = load_tog_i;
      bytes_d  = '0;
    end else begin
      if (evt.ack) begin
        if (!phase_q) begin
          phase_d = 1'b1;
        end else begin
          tog_d    = ~tog_q;
          bytes_d  = res_bytes_i;
          retire_d = 1'b1;
        end
      end
      if (evt.fault && err_expire) begin
        xerr_d   = 1'b1;
        retire_d = 1'b1;
      end
      if (evt.nak && nak_expire) begin
        retire_d = 1'b1;
      end
      if (evt.babble) begin
        babble_d = 1'b1;
        retire_d = 1'b1;
      end
      if (evt.stall) begin
        halt_d   = 1'b1;
        retire_d = 1'b1;
      end
      if (retire_d) begin
        valid_d  = 1'b0;
        active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      active_q <= 1'b0;
      halt_q   <= 1'b0;
      babble_q <= 1'b0;
      xerr_q   <= 1'b0;
      phase_q  <= 1'b0;
      tog_q    <= 1'b0;
      bytes_q  <= '0;
      retire_q <= 1'b0;
    end else begin
      retire_q <= retire_d;
      if (load_i | accept) begin
        valid_q  <= valid_d;
        active_q <= active_d;
        halt_q   <= halt_d;
        babble_q <= babble_d;
        xerr_q   <= xerr_d;
        phase_q  <= phase_d;
        tog_q    <= tog_d;
        bytes_q  <= bytes_d;
      end
    end
  end

  assign valid_o    = valid_q;
  assign active_o   = active_q;
  assign halt_o     = halt_q;
  assign babble_o   = babble_q;
  assign xact_err_o = xerr_q;
  assign phase_o    = phase_q;
  assign toggle_o   = tog_q;
  assign bytes_o    = bytes_q;
  assign retire_o   = retire_q;

endmodule

// File: rtl/split_td_status_chk.sv
module split_td_status_chk #(
  parameter int ERR_W  = 2,
  parameter int NAK_W  = 4,
  parameter int BYTE_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              res_vld_i,
  input logic [2:0]        res_code_i,
  input logic              valid_o,
  input logic              active_o,
  input logic              halt_o,
  input logic              babble_o,
  input logic              xact_err_o,
  input logic              phase_o,
  input logic              toggle_o,
  input logic [ERR_W-1:0]  err_cnt_o,
  input logic [NAK_W-1:0]  nak_cnt_o,
  input logic [BYTE_W-1:0] bytes_o,
  input logic              retire_o
);

  logic taken;
  assign taken = res_vld_i & valid_o & ~load_i;

  // R2
  ignore_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_i && !valid_o && !load_i) |=> ($stable(phase_o) && $stable(toggle_o)
      && $stable(bytes_o) && $stable(err_cnt_o) && $stable(nak_cnt_o) && !retire_o));

  // R3
  start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && res_code_i == 3'd0 && !phase_o) |=> (phase_o && valid_o && !retire_o));

  // R5
  xerr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xact_err_o) |-> (err_cnt_o == '0 && !valid_o));

  // R9
  babble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && res_code_i == 3'd5) |=> (babble_o && !valid_o && !active_o && retire_o));

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && res_code_i == 3'd6) |=> (halt_o && !valid_o && !active_o && retire_o));

  // R11
  retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |-> (!valid_o && $past(valid_o)));

  // R12
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (valid_o && active_o && !phase_o && !halt_o && !babble_o
      && !xact_err_o && bytes_o == '0 && !retire_o));

endmodule

bind split_td_status split_td_status_chk #(
  .ERR_W(ERR_W), .NAK_W(NAK_W), .BYTE_W(BYTE_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .res_vld_i  (res_vld_i),
  .res_code_i (res_code_i),
  .valid_o    (valid_o),
  .active_o   (active_o),
  .halt_o     (halt_o),
  .babble_o   (babble_o),
  .xact_err_o (xact_err_o),
  .phase_o    (phase_o),
  .toggle_o   (toggle_o),
  .err_cnt_o  (err_cnt_o),
  .nak_cnt_o  (nak_cnt_o),
  .bytes_o    (bytes_o),
  .retire_o   (retire_o)
);

// File: tb/split_td_status_tb_top.sv
module split_td_status_tb_top;

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [1:0]  load_err_i;
  logic [3:0]  load_rl_i;
  logic        load_tog_i;
  logic        res_vld_i;
  logic [2:0]  res_code_i;
  logic [14:0] res_bytes_i;
  logic        valid_o, active_o, halt_o, babble_o, xact_err_o;
  logic        phase_o, toggle_o, retire_o;
  logic [1:0]  err_cnt_o;
  logic [3:0]  nak_cnt_o;
  logic [14:0] bytes_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  split_td_status dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_err_i(load_err_i),
    .load_rl_i(load_rl_i), .load_tog_i(load_tog_i), .res_vld_i(res_vld_i),
    .res_code_i(res_code_i), .res_bytes_i(res_bytes_i), .valid_o(valid_o),
    .active_o(active_o), .halt_o(halt_o), .babble_o(babble_o),
    .xact_err_o(xact_err_o), .phase_o(phase_o), .toggle_o(toggle_o),
    .err_cnt_o(err_cnt_o), .nak_cnt_o(nak_cnt_o), .bytes_o(bytes_o),
    .retire_o(retire_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive a load for one cycle; outputs are valid at the following negedge.
  task automatic arm(input logic [1:0] e, input logic [3:0] rl, input logic t);
    @(negedge clk);
    load_i = 1'b1; load_err_i = e; load_rl_i = rl; load_tog_i = t;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic strobe(input logic [2:0] code, input logic [14:0] n);
    @(negedge clk);
    res_vld_i = 1'b1; res_code_i = code; res_bytes_i = n;
    @(negedge clk);
    res_vld_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "reset valid", valid_o, 0);
    check("R1", "reset flags", {halt_o, babble_o, xact_err_o, phase_o, retire_o}, 0);
    check("R1", "reset counters", {err_cnt_o, nak_cnt_o, bytes_o}, 0);
  endtask

  task automatic t_load;
    arm(2'd3, 4'd5, 1'b0);
    check("R1", "valid/active", {valid_o, active_o}, 2'b11);
    check("R1", "phase/toggle", {phase_o, toggle_o}, 0);
    check("R1", "err_cnt", err_cnt_o, 3);
    check("R1", "nak_cnt", nak_cnt_o, 5);
  endtask

  task automatic t_start_then_complete;
    strobe(3'd0, 15'd9);
    check("R3", "phase after start ack", phase_o, 1);
    check("R3", "valid after start ack", valid_o, 1);
    check("R3", "no retire", retire_o, 0);
    strobe(3'd3, 15'd0);
    check("R5", "err dec", err_cnt_o, 2);
    strobe(3'd2, 15'd0);
    check("R6", "nyet reload", err_cnt_o, 3);
    check("R8", "phase after nyet", phase_o, 1);
    strobe(3'd0, 15'd100);
    check("R4", "toggle flipped", toggle_o, 1);
    check("R4", "bytes", bytes_o, 100);
    check("R4", "valid/active clear", {valid_o, active_o}, 0);
    check("R11", "retire pulse", retire_o, 1);
    @(negedge clk);
    check("R11", "retire one cycle", retire_o, 0);
  endtask

  task automatic t_ignored;
    strobe(3'd0, 15'd7);
    check("R2", "ignored while invalid bytes", bytes_o, 100);
    check("R2", "ignored while invalid phase/toggle", {phase_o, toggle_o}, 2'b11);
    check("R2", "no retire", retire_o, 0);
    arm(2'd2, 4'd3, 1'b1);
    strobe(3'd7, 15'd5);
    check("R2", "reserved code state", {valid_o, phase_o, err_cnt_o, nak_cnt_o}, {1'b1, 1'b0, 2'd2, 4'd3});
    check("R2", "reserved bytes", bytes_o, 0);
  endtask

  task automatic t_err_retire;
    arm(2'd2, 4'd0, 1'b0);
    strobe(3'd4, 15'd0);
    check("R5", "err 2->1", err_cnt_o, 1);
    check("R5", "still valid", valid_o, 1);
    strobe(3'd3, 15'd0);
    check("R5", "err at zero", err_cnt_o, 0);
    check("R5", "xact_err set, valid clear", {xact_err_o, valid_o, active_o}, 3'b100);
    check("R11", "retire on err", retire_o, 1);
  endtask

  task automatic t_nak;
    arm(2'd1, 4'd2, 1'b0);
    strobe(3'd3, 15'd0);
    check("R5", "budget 1 exhausted at once", {xact_err_o, valid_o}, 2'b10);
    arm(2'd2, 4'd2, 1'b0);
    strobe(3'd3, 15'd0);
    strobe(3'd1, 15'd0);
    check("R6", "nak reload err", err_cnt_o, 2);
    check("R7", "nak 2->1", nak_cnt_o, 1);
    check("R8", "phase stays start", phase_o, 0);
    strobe(3'd1, 15'd0);
    check("R7", "nak retire", {nak_cnt_o, valid_o, retire_o}, {4'd0, 1'b0, 1'b1});
    arm(2'd3, 4'd0, 1'b0);
    for (int k = 0; k < 20; k++) strobe(3'd1, 15'd0);
    check("R7", "rl zero no change", {nak_cnt_o, valid_o}, {4'd0, 1'b1});
  endtask

  task automatic t_babble_stall;
    arm(2'd3, 4'd4, 1'b0);
    strobe(3'd5, 15'd0);
    check("R9", "babble", {babble_o, valid_o, active_o, halt_o}, 4'b1000);
    arm(2'd3, 4'd4, 1'b0);
    check("R1", "babble cleared by load", babble_o, 0);
    strobe(3'd6, 15'd0);
    check("R10", "stall", {halt_o, valid_o, active_o, babble_o}, 4'b1000);
  endtask

  task automatic t_collision;
    arm(2'd2, 4'd6, 1'b0);
    strobe(3'd3, 15'd0);
    @(negedge clk);
    load_i = 1'b1; load_err_i = 2'd3; load_rl_i = 4'd7; load_tog_i = 1'b1;
    res_vld_i = 1'b1; res_code_i = 3'd6; res_bytes_i = 15'd0;
    @(negedge clk);
    load_i = 1'b0; res_vld_i = 1'b0;
    check("R12", "halt not set", halt_o, 0);
    check("R12", "valid kept", {valid_o, retire_o}, 2'b10);
    check("R12", "counters reloaded", {err_cnt_o, nak_cnt_o, toggle_o}, {2'd3, 4'd7, 1'b1});
  endtask

  initial begin
    rst_n = 1'b0; load_i = 1'b0; load_err_i = '0; load_rl_i = '0; load_tog_i = 1'b0;
    res_vld_i = 1'b0; res_code_i = '0; res_bytes_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_start_then_complete();
    t_ignored();
    t_err_retire();
    t_nak();
    t_babble_stall();
    t_collision();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule